// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block drives eight per-priority transmit fetch gates on one egress port from a gate-control list. Each list entry is one command word. The word holds a fetch-allow mask, where bit i opens priority i, and a duration counted in line units. The command store has two equal halves. Software fills the half that is not in use and then points the buffer-select input at it. The block switches over only at the next cycle-start pulse, so a list that is running is never replaced partway through a cycle.

Each cycle-start pulse restarts execution at slot 0 of the active half. Each command holds its mask until its duration runs out. The next command is then fetched. A count of zero ends the list early, and so does completing the last slot of the half. At that point the gates that no timed command opened during the cycle are opened instead. That trailing mask is held until the next pulse. Durations count bytes at gigabit and nibbles at 10/100. The unit tick input pulses once per nibble time on the wire.

Top module: `tgs_gate_sched`

## Requirements
- R1: After synchronous reset, all gate outputs are open (all ones), the active-half status is 0, and no list executes until a cycle-start pulse is sampled while enabled.
- R2: A command word carries the duration in bits [21:8] and the fetch-allow mask in bits [7:0], where bit i set opens priority i. The write address MSB selects the half and the low bits select one of 8 slots.
- R3: The active-half status takes the value of the buffer-select input only at a clock edge where the cycle-start pulse is sampled high. At every other edge it keeps its value, even while the buffer-select input differs.
- R4: A cycle-start pulse sampled while enabled restarts execution at slot 0 of the newly active half. The gates change to that slot's mask at the following clock edge, so a pulse that arrives in the middle of a list abandons the rest of that list.
- R5: A command with count N keeps its mask on the gates for N unit decrements plus one clock for fetching the next command. With the gigabit input low, every tick is one decrement. With it high, every second tick is one decrement, and the tick pairing restarts at each command load.
- R6: A nonzero count below 16 is executed as 16.
- R7: A command with a zero count ends the list, and later slots have no effect. The gates then take the bitwise complement of the union of the masks loaded since the cycle start, and hold it until the next pulse.
- R8: When the last slot of a half completes, the gates take the same trailing mask as in R7.
- R9: Consecutive commands with the same mask keep the gates unchanged across the boundary, so one long interval can be split over several commands.
- R10: Gating needs both the port enable and the global enable. If either is low at an edge, the gates are all open from that edge and execution stops. Execution resumes only at a later cycle-start pulse.
- R11: Writes to the inactive half while a list is running do not change the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command store write strobe |
| wr_addr | input | 4 | Write address: {half, slot} |
| wr_data | input | 22 | Command word: {count[13:0], mask[7:0]} |
| buf_sel | input | 1 | Half requested for the next cycle |
| act_buf | output | 1 | Half currently executing |
| port_en | input | 1 | Port-level gating enable |
| glob_en | input | 1 | Global gating enable |
| cycle_start | input | 1 | One-clock pulse marking the gate cycle boundary |
| gig_mode | input | 1 | 1: counts are bytes (two ticks each); 0: counts are nibbles |
| unit_tick | input | 1 | One pulse per nibble time on the wire |
| gate | output | 8 | Registered per-priority fetch-allow output |

## Verification
The cycle-start pulse can land in the same clock as a command running out. A restart and a fetch of the next slot then compete for the read address and the gate register. The bench provokes this with pulses at pseudo-random times under pseudo-random ticks in both speed modes. It also pulses on a cycle where the list is mid-command. A buffer-select change and disable edges can coincide with pulses as well. Every clock, a behavioural model predicts the gate vector and the active half, and both outputs are compared against it. Fixed checks pin the hand-computed durations, the trailing masks and the swap timing.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tgs_cmd_ram.sv
module tgs_cmd_ram #(
  parameter int WORD_W = 22,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // read-first single-clock store, registered read for block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tgs_bank_sel.sv
module tgs_bank_sel (
  input  logic clk,
  input  logic rst,
  input  logic cycle_start,
  input  logic buf_sel,
  output logic act_q,
  output logic act_next
);
  always_comb act_next = cycle_start ? buf_sel : act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act_next;
  end

  // R3: the executing half only moves at a cycle boundary
  p_act_steady_r3: assert property (@(posedge clk) disable iff (rst)
    !cycle_start |=> $stable(act_q));

  // R3: at a boundary the requested half becomes active
  p_act_follow_r3: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> (act_q == $past(buf_sel)));
endmodule

// File: rtl/tgs_sequencer.sv
module tgs_sequencer
  import tgs_pkg::*;
#(
  parameter int PRIO_N  = 8,
  parameter int CNT_W   = 14,
  parameter int SLOTS   = 8,
  parameter int MIN_CNT = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     cycle_start,
  input  logic                     tick,
  input  logic                     gig,
  input  logic [CNT_W-1:0]         cmd_cnt,
  input  logic [PRIO_N-1:0]        cmd_mask,
  output logic [$clog2(SLOTS)-1:0] rd_idx,
  output logic [PRIO_N-1:0]        gate
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_CNT);
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

  seq_state_e        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              half_q;
  logic [PRIO_N-1:0] seen_q;
  logic [PRIO_N-1:0] gate_q;

  logic              dec;
  logic              expire;
  logic [CNT_W-1:0]  cnt_load;

  // one decrement per tick at 10/100, per tick pair at gigabit
  always_comb dec    = tick && (!gig || half_q);
  always_comb expire = (st_q == ST_RUN) && dec && (cnt_q == ONE_C);
  always_comb cnt_load = (cmd_cnt < MIN_C) ? MIN_C : cmd_cnt;

  // address of the command to be present in the read register next cycle
  always_comb begin
    if (!en || cycle_start)               rd_idx = '0;
    else if (expire && idx_q != LAST_IDX) rd_idx = idx_q + 1'b1;
    else                                  rd_idx = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      seen_q <= '0;
      gate_q <= '1;
    end else if (!en) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      gate_q <= '1;
    end else if (cycle_start) begin
      st_q   <= ST_FETCH;
      idx_q  <= '0;
      seen_q <= '0;
    end else begin
      case (st_q)
        ST_FETCH: begin
          if (cmd_cnt == '0) begin
            st_q   <= ST_DONE;
            gate_q <= ~seen_q;
          end else begin
            st_q   <= ST_RUN;
            cnt_q  <= cnt_load;
            gate_q <= cmd_mask;
            seen_q <= seen_q | cmd_mask;
            half_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tick) half_q <= ~half_q;
          if (dec) begin
            if (cnt_q == ONE_C) begin
              if (idx_q == LAST_IDX) begin
                st_q   <= ST_DONE;
                gate_q <= ~seen_q;
              end else begin
                st_q  <= ST_FETCH;
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q - ONE_C;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb gate = gate_q;

  // R10: losing either enable opens every gate at the next edge
  p_open_when_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate == '1));

  // R6: a loaded nonzero duration is never shorter than the floor
  p_count_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !cycle_start && st_q == ST_FETCH && cmd_cnt != '0) |=> (cnt_q >= MIN_C));

  // R5: without a decrement the running command is frozen
  p_hold_no_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !cycle_start && st_q == ST_RUN && !dec) |=> ($stable(cnt_q) && $stable(gate)));

  // R7: the trailing mask is held until the next boundary
  p_trail_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !cycle_start && st_q == ST_DONE) |=> $stable(gate));

  // R7: the trailing mask opens nothing that a timed command already opened
  p_trail_disjoint_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |-> ((gate & seen_q) == '0));
endmodule

// File: rtl/tgs_gate_sched.sv
module tgs_gate_sched #(
  parameter int PRIO_N  = 8,
  parameter int CNT_W   = 14,
  parameter int SLOTS   = 8,
  parameter int MIN_CNT = 16,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int ADDR_W = IDX_W + 1,
  localparam int WORD_W = CNT_W + PRIO_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              buf_sel,
  output logic              act_buf,
  input  logic              port_en,
  input  logic              glob_en,
  input  logic              cycle_start,
  input  logic              gig_mode,
  input  logic              unit_tick,
  output logic [PRIO_N-1:0] gate
);
  logic              en;
  logic              act_q;
  logic              act_next;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;

  always_comb en = port_en && glob_en;

  tgs_bank_sel u_bank (
    .clk         (clk),
    .rst         (rst),
    .cycle_start (cycle_start),
    .buf_sel     (buf_sel),
    .act_q       (act_q),
    .act_next    (act_next)
  );

  tgs_cmd_ram #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr ({act_next, rd_idx}),
    .rdata (rd_word)
  );

  tgs_sequencer #(
    .PRIO_N  (PRIO_N),
    .CNT_W   (CNT_W),
    .SLOTS   (SLOTS),
    .MIN_CNT (MIN_CNT)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .cycle_start (cycle_start),
    .tick        (unit_tick),
    .gig         (gig_mode),
    .cmd_cnt     (rd_word[WORD_W-1:PRIO_N]),
    .cmd_mask    (rd_word[PRIO_N-1:0]),
    .rd_idx      (rd_idx),
    .gate        (gate)
  );

  always_comb act_buf = act_q;
endmodule

// File: tb/tgs_gate_sched_bench.sv
`timescale 1ns/1ps
module tgs_gate_sched_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [21:0] wr_data = '0;
  logic        buf_sel = 1'b0;
  logic        port_en = 1'b0;
  logic        glob_en = 1'b0;
  logic        cycle_start = 1'b0;
  logic        gig_mode = 1'b0;
  logic        unit_tick = 1'b0;
  logic        act_buf;
  logic [7:0]  gate;

  always #2 clk = ~clk;

  tgs_gate_sched u_tgs_gate_sched (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_sel(buf_sel), .act_buf(act_buf), .port_en(port_en), .glob_en(glob_en),
    .cycle_start(cycle_start), .gig_mode(gig_mode), .unit_tick(unit_tick), .gate(gate)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc_cnt = 0;
  string cur_req = "R1";

  // behavioural reference: mode 0 idle, 1 loading, 2 counting, 3 trailing
  int          m_mode = 0;
  int          m_pos = 0;
  int          m_left = 0;
  int          m_phase = 0;
  logic [7:0]  m_gate = 8'hFF;
  logic [7:0]  m_seen = 8'h00;
  logic        m_act = 1'b0;
  logic [21:0] m_mem [16];

  logic        tick_all = 1'b0;
  logic        tick_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  initial for (int i = 0; i < 16; i++) m_mem[i] = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_pos = 0; m_left = 0; m_phase = 0;
      m_gate = 8'hFF; m_seen = 8'h00; m_act = 1'b0;
    end else begin
      if (!(port_en && glob_en)) begin
        m_mode = 0; m_pos = 0; m_gate = 8'hFF;
      end else if (cycle_start) begin
        m_mode = 1; m_pos = 0; m_seen = 8'h00;
      end else if (m_mode == 1) begin
        int dur;
        dur = int'(m_mem[{m_act, 3'(m_pos)}][21:8]);
        if (dur == 0) begin
          m_mode = 3; m_gate = ~m_seen;
        end else begin
          m_left = (dur < 16) ? 16 : dur;
          m_gate = m_mem[{m_act, 3'(m_pos)}][7:0];
          m_seen = m_seen | m_gate;
          m_phase = 0; m_mode = 2;
        end
      end else if (m_mode == 2 && unit_tick) begin
        bit step;
        step = !gig_mode || (m_phase == 1);
        m_phase = 1 - m_phase;
        if (step) begin
          if (m_left == 1) begin
            if (m_pos == 7) begin m_mode = 3; m_gate = ~m_seen; end
            else begin m_pos++; m_mode = 1; end
          end else m_left--;
        end
      end
      if (cycle_start) m_act = buf_sel;
      if (wr_en) m_mem[wr_addr] = wr_data;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    checks++;
    if (gate !== m_gate || act_buf !== m_act) begin
      failures++;
      $display("FAIL %s: gate=%h act=%b expected gate=%h act=%b",
               cur_req, gate, act_buf, m_gate, m_act);
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    unit_tick <= tick_rand ? lfsr[3] : tick_all;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cyc_cnt);
      summary();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int dur, input logic [7:0] mask);
    wr_en = 1'b1; wr_addr = a; wr_data = {14'(dur), mask};
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    cycle_start = 1'b1;
    step(1);
    cycle_start = 1'b0;
  endtask

  task automatic run_len(input logic [7:0] mask, output int len);
    int guard;
    len = 0; guard = 0;
    while (gate != mask && guard < 2000) begin step(1); guard++; end
    while (gate == mask && len < 2000) begin step(1); len++; end
  endtask

  initial begin
    int len;
    step(3);
    rst = 1'b0;
    step(1);
    cur_req = "R1";
    check(gate == 8'hFF, "R1 reset gate", gate, 8'hFF);
    check(act_buf == 1'b0, "R1 reset active half", act_buf, 0);

    // list in half 0: 20 units, short (clamped) entry, terminator, dead entry
    cur_req = "R2";
    wr(4'd0, 20, 8'h03);
    wr(4'd1, 5, 8'h0C);
    wr(4'd2, 0, 8'hAA);
    wr(4'd3, 30, 8'hF0);
    port_en = 1'b1; glob_en = 1'b1; tick_all = 1'b1;
    step(3);
    check(gate == 8'hFF, "R1 idle before first boundary", gate, 8'hFF);
    pulse();
    run_len(8'h03, len);
    check(len == 21, "R2 R5 nibble duration", len, 21);
    cur_req = "R6";
    run_len(8'h0C, len);
    check(len == 17, "R6 short count floored", len, 17);
    cur_req = "R7";
    step(2);
    check(gate == 8'hF0, "R7 trailing mask after terminator", gate, 8'hF0);
    step(20);
    check(gate == 8'hF0, "R7 trailing mask held", gate, 8'hF0);

    // gigabit: two ticks per unit
    cur_req = "R5";
    gig_mode = 1'b1;
    pulse();
    run_len(8'h03, len);
    check(len == 41, "R5 byte duration at gigabit", len, 41);
    step(40);
    gig_mode = 1'b0;

    // fill the idle half during a running list, then swap at the boundary
    cur_req = "R11";
    pulse();
    step(2);
    wr(4'd8, 16, 8'h11);
    wr(4'd9, 16, 8'h11);
    wr(4'd10, 0, 8'h00);
    cur_req = "R3";
    buf_sel = 1'b1;
    step(3);
    check(act_buf == 1'b0, "R3 no swap before boundary", act_buf, 0);
    step(50);
    check(act_buf == 1'b0, "R3 no swap after list end", act_buf, 0);
    pulse();
    check(act_buf == 1'b1, "R3 swap at boundary", act_buf, 1);
    cur_req = "R9";
    run_len(8'h11, len);
    check(len == 34, "R9 split interval continuous", len, 34);
    step(2);
    check(gate == 8'hEE, "R7 trailing mask of new half", gate, 8'hEE);

    // mid-list restart
    cur_req = "R4";
    buf_sel = 1'b0;
    pulse();
    step(25);
    check(gate == 8'h0C, "R4 second slot running", gate, 8'h0C);
    pulse();
    run_len(8'h03, len);
    check(len == 21, "R4 restart from slot 0", len, 21);
    step(30);

    // full half without terminator
    cur_req = "R8";
    for (int i = 0; i < 8; i++) wr(4'(8 + i), 16, 8'(1 << (i % 4)));
    buf_sel = 1'b1;
    pulse();
    step(2);
    check(gate == 8'h01, "R8 first slot", gate, 8'h01);
    step(140);
    check(gate == 8'hF0, "R8 trailing mask after last slot", gate, 8'hF0);

    // enables
    cur_req = "R10";
    pulse();
    step(10);
    glob_en = 1'b0;
    step(1);
    check(gate == 8'hFF, "R10 global disable opens gates", gate, 8'hFF);
    glob_en = 1'b1;
    step(5);
    check(gate == 8'hFF, "R10 no resume without boundary", gate, 8'hFF);
    pulse();
    step(3);
    check(gate == 8'h01, "R10 resume at boundary", gate, 8'h01);
    port_en = 1'b0;
    step(2);
    check(gate == 8'hFF, "R10 port disable opens gates", gate, 8'hFF);
    port_en = 1'b1;

    // random ticks, pulses at arbitrary points, both speeds
    cur_req = "R5";
    tick_all = 1'b0; tick_rand = 1'b1;
    for (int k = 0; k < 12; k++) begin
      gig_mode = k[0];
      buf_sel = k[1];
      pulse();
      step(20 + 17 * k);
    end
    cur_req = "R4";
    for (int k = 0; k < 40; k++) begin
      if (lfsr[7]) pulse(); else step(1);
      step(int'(lfsr[5:0]));
    end
    step(5);
    summary();
  end
endmodule